// File: doc/BRIEF.md
# Segmented Biased Triple-Multiple Generator Modulo 2^n-1

This block produces the hard multiple of a radix-8 Booth multiplier working modulo 2^n-1: the value 3X, kept in a partially redundant form with a bias added. X and its one-bit left rotation (which is 2X modulo 2^n-1) are added in M = n/k independent ripple-carry segments of k bits. No carry passes from one segment to the next. Each segment's carry-out is kept as a separate bit at the weight of the following segment's lowest bit. The carry-out of the top segment has weight 2^n, which is congruent to 1, so it wraps round to bit 0. The longest carry chain is therefore k bits, and k sets the adder delay.

A bias B, with ones only at the segment boundary bits k·j, is folded in at each boundary. At a boundary the sum bit and the incoming carry feed one XNOR gate and one OR gate. The biased pair therefore keeps a sparse carry vector, with ones possible only at bits k·j+1. The block also delivers the pair for B-3X. Its sum is the bitwise complement of the biased sum. Its carry is the complement of the biased carry, taken at the k·j+1 positions only. The pair for B+3X and the pair for B-3X add up to 2B modulo 2^n-1. A downstream Booth selector picks one of the two pairs. The results are registered one cycle after the input is accepted.

Top module: `mod_hard3x_gen`

## Requirements
- R1: One cycle after an accepted input X, (pos_sum + pos_carry) mod (2^n-1) equals (B + 3·X) mod (2^n-1), where B has ones exactly at bits k·j for j = 0..M-1 (B = 0x11 for n=8, k=4).
- R2: In the same cycle, (neg_sum + neg_carry) mod (2^n-1) equals (B - 3·X) mod (2^n-1).
- R3: pos_carry has ones only at bit positions k·j+1 (mask 0x22 for n=8, k=4); every other bit is 0.
- R4: neg_carry has ones only at bit positions k·j+1; every other bit is 0.
- R5: neg_sum is the bitwise complement of pos_sum. At bits k·j+1, neg_carry is the complement of pos_carry.
- R6: out_valid equals in_valid delayed by one cycle. While in_valid is low, all four data outputs hold their previous values.
- R7: While rst is high, out_valid and all data outputs are cleared to 0 at each clock edge.
- R8: The carry-out of the top segment wraps to weight 2^0 and is then biased into bit 1. For n=8, k=4: X=0xF0 gives pos_sum=0xC1 and pos_carry=0x22. X=0xFF gives pos_sum=0xEE and pos_carry=0x22. X=0x00 gives pos_sum=0x11 and pos_carry=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept x_in on this edge |
| x_in | input | N | Multiplicand residue X |
| out_valid | output | 1 | Registered result valid |
| pos_sum | output | N | Biased sum vector for B+3X |
| pos_carry | output | N | Sparse carry vector for B+3X |
| neg_sum | output | N | Sum vector for B-3X |
| neg_carry | output | N | Sparse carry vector for B-3X |

## Verification
The residue assertions assume that N is a multiple of K, that K is at least 2 so that a boundary's carry bit at k·j+1 never lands on the next boundary, and that N is small enough for the residue sums to fit in 64-bit arithmetic. They also assume that x_in is a known value whenever in_valid is high. The bench keeps to the default n=8, k=4 configuration. It drives every one of the 256 values of X, then random values from a fixed seed interleaved with idle cycles. Directed values test the wrap-around carry and the all-zero and all-one residues.

// File: rtl/hard3x_pkg.sv
package hard3x_pkg;

    localparam int DEF_WIDTH = 8;
    localparam int DEF_SEG   = 4;

    // Mask with ones at bit (k*j + off) mod n for every segment j.
    function automatic logic [63:0] boundary_mask(input int n, input int k, input int off);
        logic [63:0] m;
        m = '0;
        for (int j = 0; j < n / k; j++) begin
            m[(k * j + off) % n] = 1'b1;
        end
        return m;
    endfunction

    // Residue modulo 2^n-1 of a value in 64-bit arithmetic.
    function automatic longint unsigned resid(input longint unsigned v, input int n);
        longint unsigned md;
        md = (64'd1 << n) - 64'd1;
        return v % md;
    endfunction

endpackage

// File: rtl/seg_ripple_add.sv
module seg_ripple_add #(
    parameter int K = 4
) (
    input  logic [K-1:0] a,
    input  logic [K-1:0] b,
    output logic [K-1:0] sum,
    output logic         cout
);
    logic [K:0] chain;

    always_comb begin
        chain[0] = 1'b0;
        for (int i = 0; i < K; i++) begin
            sum[i]     = a[i] ^ b[i] ^ chain[i];
            chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
        end
        cout = chain[K];
    end
endmodule

// File: rtl/bias_fold.sv
module bias_fold #(
    parameter int N = 8,
    parameter int K = 4,
    localparam int M = N / K
) (
    input  logic [N-1:0] raw_sum,
    input  logic [M-1:0] cin_at,   // carry arriving at boundary k*j
    output logic [N-1:0] b_sum,
    output logic [N-1:0] b_carry
);
    always_comb begin
        b_sum   = raw_sum;
        b_carry = '0;
        for (int j = 0; j < M; j++) begin
            b_sum[K*j]           = ~(raw_sum[K*j] ^ cin_at[j]);
            b_carry[(K*j+1) % N] = raw_sum[K*j] | cin_at[j];
        end
    end
endmodule

// File: rtl/neg_pair.sv
module neg_pair #(
    parameter int N = 8,
    parameter int K = 4
) (
    input  logic [N-1:0] p_sum,
    input  logic [N-1:0] p_carry,
    output logic [N-1:0] n_sum,
    output logic [N-1:0] n_carry
);
    import hard3x_pkg::*;

    localparam logic [63:0] CMASK_W = boundary_mask(N, K, 1);
    localparam logic [N-1:0] CMASK  = CMASK_W[N-1:0];

    assign n_sum   = ~p_sum;
    assign n_carry = ~p_carry & CMASK;
endmodule

// File: rtl/mod_hard3x_gen.sv
module mod_hard3x_gen #(
    parameter int N = hard3x_pkg::DEF_WIDTH,
    parameter int K = hard3x_pkg::DEF_SEG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [N-1:0] x_in,
    output logic         out_valid,
    output logic [N-1:0] pos_sum,
    output logic [N-1:0] pos_carry,
    output logic [N-1:0] neg_sum,
    output logic [N-1:0] neg_carry
);
    import hard3x_pkg::*;

    localparam int M = N / K;
    localparam logic [63:0] BIAS_W  = boundary_mask(N, K, 0);
    localparam logic [63:0] CMASK_W = boundary_mask(N, K, 1);
    localparam logic [N-1:0] CMASK  = CMASK_W[N-1:0];

    typedef struct packed {
        logic [N-1:0] ps;
        logic [N-1:0] pc;
        logic [N-1:0] ns;
        logic [N-1:0] nc;
    } pairs_t;

    logic [N-1:0] x_dbl;
    logic [N-1:0] raw_sum;
    logic [M-1:0] seg_co;
    logic [M-1:0] cin_at;
    pairs_t       nxt;
    pairs_t       q;
    logic         vld_q;

    // 2X modulo 2^n-1 is a left rotation by one
    assign x_dbl = {x_in[N-2:0], x_in[N-1]};

    generate
        for (genvar j = 0; j < M; j++) begin : g_seg
            seg_ripple_add #(.K(K)) u_seg (
                .a    (x_in[j*K +: K]),
                .b    (x_dbl[j*K +: K]),
                .sum  (raw_sum[j*K +: K]),
                .cout (seg_co[j])
            );
            // carry of segment j-1 arrives at boundary j; top carry wraps to 0
            assign cin_at[j] = seg_co[(j + M - 1) % M];
        end
    endgenerate

    bias_fold #(.N(N), .K(K)) u_fold (
        .raw_sum (raw_sum),
        .cin_at  (cin_at),
        .b_sum   (nxt.ps),
        .b_carry (nxt.pc)
    );

    neg_pair #(.N(N), .K(K)) u_neg (
        .p_sum   (nxt.ps),
        .p_carry (nxt.pc),
        .n_sum   (nxt.ns),
        .n_carry (nxt.nc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                q <= nxt;
            end
        end
    end

    assign out_valid = vld_q;
    assign pos_sum   = q.ps;
    assign pos_carry = q.pc;
    assign neg_sum   = q.ns;
    assign neg_carry = q.nc;

    // Residue checks on the combinational pairs against the arithmetic value
    always_comb begin
        if (!rst && in_valid) begin
            assert_pos_residue_R1: assert (
                resid(longint'(nxt.ps) + longint'(nxt.pc), N) ==
                resid(BIAS_W[N-1:0] + 64'd3 * longint'(x_in), N));
            assert_neg_residue_R2: assert (
                resid(longint'(nxt.ns) + longint'(nxt.nc) + 64'd3 * longint'(x_in), N) ==
                resid(BIAS_W[N-1:0], N));
        end
    end

    assert_pos_sparse_R3: assert property (@(posedge clk) disable iff (rst)
        (pos_carry & ~CMASK) == '0);

    assert_neg_sparse_R4: assert property (@(posedge clk) disable iff (rst)
        (neg_carry & ~CMASK) == '0);

    assert_compl_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (neg_sum == ~pos_sum) && ((neg_carry ^ pos_carry) == CMASK));

    assert_valid_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(pos_sum) && $stable(pos_carry)
                      && $stable(neg_sum) && $stable(neg_carry));

    assert_reset_R7: assert property (@(posedge clk)
        rst |=> !out_valid && pos_sum == '0 && pos_carry == '0);

endmodule

// File: tb/sim_mod_hard3x_gen.sv
module sim_mod_hard3x_gen;
    localparam int  N       = 8;
    localparam int  K       = 4;
    localparam time CLK_PER = 10ns;
    localparam int  MODV    = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [N-1:0] x_in = '0;
    logic         out_valid;
    logic [N-1:0] pos_sum, pos_carry, neg_sum, neg_carry;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    mod_hard3x_gen #(.N(N), .K(K)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in),
        .out_valid(out_valid), .pos_sum(pos_sum), .pos_carry(pos_carry),
        .neg_sum(neg_sum), .neg_carry(neg_carry)
    );

    function automatic int bias_val();
        int b = 0;
        for (int j = 0; j < N / K; j++) b |= (1 << (K * j));
        return b;
    endfunction

    function automatic int cmask_val();
        int m = 0;
        for (int j = 0; j < N / K; j++) m |= (1 << ((K * j + 1) % N));
        return m;
    endfunction

    function automatic int exp_pos(input int x);
        return (bias_val() + 3 * x) % MODV;
    endfunction

    function automatic int exp_neg(input int x);
        return (bias_val() + 3 * MODV - 3 * x) % MODV;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // apply one value; result sampled at the following negedge
    task automatic apply_and_check(input int x);
        int ps, pc, ns, nc;
        @(negedge clk);
        in_valid = 1'b1;
        x_in     = x[N-1:0];
        @(negedge clk);
        ps = int'(pos_sum); pc = int'(pos_carry);
        ns = int'(neg_sum); nc = int'(neg_carry);
        chk("R1 pos residue", (ps + pc) % MODV, exp_pos(x));
        chk("R2 neg residue", (ns + nc) % MODV, exp_neg(x));
        chk("R3 pos carry sparse", pc & ~cmask_val(), 0);
        chk("R4 neg carry sparse", nc & ~cmask_val(), 0);
        chk("R5 sum complement", ns, (~ps) & MODV);
        chk("R5 carry complement", nc, (~pc) & cmask_val());
        chk("R6 valid", int'(out_valid), 1);
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        in_valid = 1'b1;
        x_in     = 8'hA5;
        repeat (3) @(negedge clk);
        chk("R7 reset valid", int'(out_valid), 0);
        chk("R7 reset pos_sum", int'(pos_sum), 0);
        chk("R7 reset pos_carry", int'(pos_carry), 0);
        chk("R7 reset neg_sum", int'(neg_sum), 0);
        rst = 1'b0;

        // R8 directed wrap-around and extreme values
        apply_and_check(8'hF0);
        chk("R8 wrap sum", int'(pos_sum), 8'hC1);
        chk("R8 wrap carry", int'(pos_carry), 8'h22);
        apply_and_check(8'hFF);
        chk("R8 ones sum", int'(pos_sum), 8'hEE);
        chk("R8 ones carry", int'(pos_carry), 8'h22);
        apply_and_check(8'h00);
        chk("R8 zero sum", int'(pos_sum), 8'h11);
        chk("R8 zero carry", int'(pos_carry), 8'h00);

        // exhaustive sweep of X
        for (int x = 0; x < (1 << N); x++) apply_and_check(x);

        // random values with idle cycles testing hold behaviour (R6)
        for (int i = 0; i < 300; i++) begin
            int xv;
            int ps0, pc0, ns0, nc0;
            xv = int'($urandom % (1 << N));
            apply_and_check(xv);
            if ((i % 3) == 0) begin
                ps0 = int'(pos_sum); pc0 = int'(pos_carry);
                ns0 = int'(neg_sum); nc0 = int'(neg_carry);
                in_valid = 1'b0;
                x_in     = x_in ^ 8'h5A;
                @(negedge clk);
                chk("R6 idle valid", int'(out_valid), 0);
                chk("R6 hold pos_sum", int'(pos_sum), ps0);
                chk("R6 hold pos_carry", int'(pos_carry), pc0);
                chk("R6 hold neg_sum", int'(neg_sum), ns0);
                chk("R6 hold neg_carry", int'(neg_carry), nc0);
            end
        end

        // reset in mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R7 mid reset valid", int'(out_valid), 0);
        chk("R7 mid reset carry", int'(pos_carry), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule